// File: doc/BRIEF.md
# Call/Return Address Stack

This block holds the return addresses of nested subroutine calls. A call pushes the address of the following instruction; a return pops the most recent one back out. The storage is 31 words of 21 bits each. A 5-bit pointer selects the current top entry. Pointer value 0 has no word behind it and only marks an empty stack.

Besides push and pop, software can read and write the pointer and the top entry directly. A discard pop moves the pointer down without producing data. Two sticky flags record a full stack and an attempt to pop an empty one. A configuration input chooses what happens on overflow or underflow. The block either saturates and keeps running, or raises a one-cycle request for a system reset. The system reset that follows such a request clears the pointer but leaves both flags and the stored words alone. Only a power-on reset or a software flag write clears the flags.

Top module: `call_return_stack`

## Requirements
- R1: After power-on reset the pointer is 0, both flags are 0, the reset request is 0, the top-of-stack output reads 0 and no pop result is flagged valid.
- R2: A push at pointer p below 31 first moves the pointer to p+1 and then stores the push data there. One cycle later `ptr_o` is p+1 and `tos_o` shows the pushed word.
- R3: A pop at pointer p above 0 returns the word at p and lowers the pointer to p-1. `pop_vld_o` is high for exactly the following cycle, with the word on `pop_addr_o`, so words return in last-in, first-out order.
- R4: A push that moves the pointer to 31 sets the full flag. A push at pointer 31 leaves the pointer at 31, overwrites nothing (`tos_o` keeps the word stored by the push that reached 31), and sets the full flag again.
- R5: When `ovf_rst_en_i` is 1, a push that reaches 31 or is made at 31 raises `rst_req_o` for the next cycle only. A push that reaches 31 still stores its word. A following `sys_rst_i` returns the pointer to 0 while the full flag stays 1.
- R6: A pop at pointer 0 returns the value 0 with `pop_vld_o`, sets the underflow flag and leaves the pointer at 0. With `ovf_rst_en_i` = 1 it also raises `rst_req_o` for one cycle.
- R7: Both flags are sticky. `sys_rst_i` does not clear them. A write with `flag_we_i` loads them from `flag_wdata_i`, where bit 1 is full and bit 0 is underflow. If a flag-setting event happens in the same cycle as such a write, the event wins.
- R8: A pointer write loads `ptr_wdata_i` into the pointer, with values above 31 clamped to 31. The next pop returns the word stored at that entry.
- R9: A top-of-stack write replaces the word at the current pointer without moving the pointer. At pointer 0 it changes no stored word.
- R10: A discard pop lowers a nonzero pointer by one and produces no `pop_vld_o`. At pointer 0 it sets the underflow flag (and raises `rst_req_o` if enabled) and leaves the pointer at 0.
- R11: When several operations are requested in one cycle, only one takes effect. The order of precedence is `sys_rst_i`, then pointer write, then push, then pop, then discard pop, then top-of-stack write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous; clears pointer, flags and storage |
| sys_rst_i | input | 1 | Synchronous system reset; clears pointer and reset request, keeps flags and storage |
| ovf_rst_en_i | input | 1 | 1: overflow/underflow requests a reset; 0: saturate |
| push_i | input | 1 | Push request |
| push_addr_i | input | 21 | Word to push |
| pop_i | input | 1 | Pop request returning data |
| drop_i | input | 1 | Discard pop request |
| ptr_we_i | input | 1 | Pointer write strobe |
| ptr_wdata_i | input | 5 | New pointer value |
| tos_we_i | input | 1 | Top-of-stack write strobe |
| tos_wdata_i | input | 21 | New top-of-stack word |
| flag_we_i | input | 1 | Flag write strobe |
| flag_wdata_i | input | 2 | Flag values: bit 1 full, bit 0 underflow |
| pop_vld_o | output | 1 | Pop result valid (one cycle after the pop) |
| pop_addr_o | output | 21 | Popped word |
| ptr_o | output | 5 | Current pointer |
| tos_o | output | 21 | Word at the current pointer, 0 at pointer 0 |
| full_o | output | 1 | Sticky full flag |
| underflow_o | output | 1 | Sticky underflow flag |
| rst_req_o | output | 1 | One-cycle reset request |

## Verification
Three words are pushed and then popped back. Their reverse arrival order separates a true stack from a queue or from a pointer that moves on the wrong side of the access. A run of 31 pushes checks the full flag one push early and exactly at the limit, and a push past the limit shows whether entry 31 is overwritten. The same limit with the reset option on separates a saturating stack from one that requests a reset, and the following system reset shows that the flags survive it. Pointer and top-of-stack writes are then made at pointer 0, 1 and 30. Mixed-strobe cycles check the precedence order and whether a flag event beats a software flag write.

// File: rtl/rstk_pkg.sv
package rstk_pkg;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_PTRWR = 3'd1,
        OP_PUSH  = 3'd2,
        OP_POP   = 3'd3,
        OP_DROP  = 3'd4,
        OP_TOSWR = 3'd5
    } rstk_op_e;

endpackage

// File: rtl/rstk_op_arb.sv
module rstk_op_arb
    import rstk_pkg::*;
(
    input  logic     push_i,
    input  logic     pop_i,
    input  logic     drop_i,
    input  logic     ptr_we_i,
    input  logic     tos_we_i,
    output rstk_op_e op_o
);

    // Fixed precedence: pointer write, push, pop, discard, top write (R11)
    always_comb begin
        if (ptr_we_i)      op_o = OP_PTRWR;
        else if (push_i)   op_o = OP_PUSH;
        else if (pop_i)    op_o = OP_POP;
        else if (drop_i)   op_o = OP_DROP;
        else if (tos_we_i) op_o = OP_TOSWR;
        else               op_o = OP_IDLE;
    end

endmodule

// File: rtl/rstk_store.sv
module rstk_store #(
    parameter int DEPTH = 31,
    parameter int AW    = 21,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          wr_en_i,
    input  logic [PW-1:0] wr_idx_i,
    input  logic [AW-1:0] wr_data_i,
    input  logic [PW-1:0] rd_idx_i,
    output logic [AW-1:0] rd_data_o
);

    logic [AW-1:0] ent_q [1:DEPTH];
    logic [AW-1:0] ent_d [1:DEPTH];

    for (genvar gi = 1; gi <= DEPTH; gi++) begin : g_ent
        localparam logic [PW-1:0] IDX = gi[PW-1:0];

        always_comb begin
            ent_d[gi] = ent_q[gi];
            if (wr_en_i && (wr_idx_i == IDX)) ent_d[gi] = wr_data_i;
        end

        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) ent_q[gi] <= '0;
            else        ent_q[gi] <= ent_d[gi];
        end

        // R9: an entry not addressed by a write keeps its word
        a_r9_entry_hold: assert property (@(posedge clk) disable iff (!por_n)
            !(wr_en_i && (wr_idx_i == IDX)) |=> $stable(ent_q[gi]));
    end

    // Index 0 has no storage and reads as zero
    always_comb begin
        rd_data_o = '0;
        for (int i = 1; i <= DEPTH; i++) begin
            if (rd_idx_i == i[PW-1:0]) rd_data_o = ent_q[i];
        end
    end

endmodule

// File: rtl/rstk_ctrl.sv
module rstk_ctrl
    import rstk_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int AW    = 21,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_i,
    input  logic          ovf_rst_en_i,
    input  rstk_op_e      op_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic [PW-1:0] ptr_wdata_i,
    input  logic [AW-1:0] tos_wdata_i,
    input  logic          flag_we_i,
    input  logic [1:0]    flag_wdata_i,
    input  logic [AW-1:0] rd_data_i,
    output logic          wr_en_o,
    output logic [PW-1:0] wr_idx_o,
    output logic [AW-1:0] wr_data_o,
    output logic [PW-1:0] ptr_o,
    output logic          full_o,
    output logic          unf_o,
    output logic          req_o,
    output logic          pop_vld_o,
    output logic [AW-1:0] pop_addr_o
);

    localparam logic [PW-1:0] TOP  = DEPTH[PW-1:0];
    localparam logic [PW-1:0] ONE  = {{(PW-1){1'b0}}, 1'b1};
    localparam logic [PW-1:0] ZERO = '0;

    typedef struct packed {
        logic [PW-1:0] ptr;
        logic          full;
        logic          unf;
        logic          req;
        logic          pvld;
        logic [AW-1:0] pdata;
    } ctrl_t;

    ctrl_t q, d;
    logic  set_full, set_unf;

    always_comb begin
        d         = q;
        d.req     = 1'b0;
        d.pvld    = 1'b0;
        set_full  = 1'b0;
        set_unf   = 1'b0;
        wr_en_o   = 1'b0;
        wr_idx_o  = q.ptr;
        wr_data_o = '0;

        if (sys_rst_i) begin
            d.ptr = ZERO;
        end else begin
            unique case (op_i)
                OP_PTRWR: begin
                    d.ptr = (ptr_wdata_i > TOP) ? TOP : ptr_wdata_i;
                end
                OP_PUSH: begin
                    if (q.ptr >= TOP) begin
                        set_full = 1'b1;
                        d.req    = ovf_rst_en_i;
                    end else begin
                        d.ptr     = q.ptr + ONE;
                        wr_en_o   = 1'b1;
                        wr_idx_o  = q.ptr + ONE;
                        wr_data_o = push_addr_i;
                        if (q.ptr + ONE == TOP) begin
                            set_full = 1'b1;
                            d.req    = ovf_rst_en_i;
                        end
                    end
                end
                OP_POP, OP_DROP: begin
                    if (op_i == OP_POP) d.pvld = 1'b1;
                    if (q.ptr == ZERO) begin
                        set_unf = 1'b1;
                        d.req   = ovf_rst_en_i;
                        if (op_i == OP_POP) d.pdata = '0;
                    end else begin
                        d.ptr = q.ptr - ONE;
                        if (op_i == OP_POP) d.pdata = rd_data_i;
                    end
                end
                OP_TOSWR: begin
                    if (q.ptr != ZERO) begin
                        wr_en_o   = 1'b1;
                        wr_idx_o  = q.ptr;
                        wr_data_o = tos_wdata_i;
                    end
                end
                default: ;
            endcase
        end

        // Sticky flags: software load, event sets win
        d.full = (flag_we_i ? flag_wdata_i[1] : q.full) | set_full;
        d.unf  = (flag_we_i ? flag_wdata_i[0] : q.unf)  | set_unf;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) q <= '0;
        else        q <= d;
    end

    assign ptr_o      = q.ptr;
    assign full_o     = q.full;
    assign unf_o      = q.unf;
    assign req_o      = q.req;
    assign pop_vld_o  = q.pvld;
    assign pop_addr_o = q.pdata;

    a_r2_push_moves_up: assert property (@(posedge clk) disable iff (!por_n)
        (op_i == OP_PUSH && q.ptr < TOP && !sys_rst_i) |=> (q.ptr == $past(q.ptr) + ONE));

    a_r3_pop_valid_next: assert property (@(posedge clk) disable iff (!por_n)
        (op_i == OP_POP && !sys_rst_i) |=> q.pvld);

    a_r4_saturate_at_top: assert property (@(posedge clk) disable iff (!por_n)
        (op_i == OP_PUSH && q.ptr == TOP && !sys_rst_i) |=> (q.ptr == TOP && q.full));

    a_r5_req_needs_option: assert property (@(posedge clk) disable iff (!por_n)
        q.req |-> $past(ovf_rst_en_i));

    a_r6_underflow_stays_zero: assert property (@(posedge clk) disable iff (!por_n)
        ((op_i == OP_POP || op_i == OP_DROP) && q.ptr == ZERO && !sys_rst_i)
        |=> (q.unf && q.ptr == ZERO));

    a_r7_full_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (q.full && !flag_we_i) |=> q.full);

    a_r7_unf_sticky: assert property (@(posedge clk) disable iff (!por_n)
        (q.unf && !flag_we_i) |=> q.unf);

endmodule

// File: rtl/call_return_stack.sv
module call_return_stack
    import rstk_pkg::*;
#(
    parameter int DEPTH = 31,
    parameter int AW    = 21,
    parameter int PW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          por_n,
    input  logic          sys_rst_i,
    input  logic          ovf_rst_en_i,
    input  logic          push_i,
    input  logic [AW-1:0] push_addr_i,
    input  logic          pop_i,
    input  logic          drop_i,
    input  logic          ptr_we_i,
    input  logic [PW-1:0] ptr_wdata_i,
    input  logic          tos_we_i,
    input  logic [AW-1:0] tos_wdata_i,
    input  logic          flag_we_i,
    input  logic [1:0]    flag_wdata_i,
    output logic          pop_vld_o,
    output logic [AW-1:0] pop_addr_o,
    output logic [PW-1:0] ptr_o,
    output logic [AW-1:0] tos_o,
    output logic          full_o,
    output logic          underflow_o,
    output logic          rst_req_o
);

    rstk_op_e      op;
    logic          wr_en;
    logic [PW-1:0] wr_idx;
    logic [AW-1:0] wr_data;
    logic [AW-1:0] rd_data;
    logic [PW-1:0] ptr;

    rstk_op_arb u_arb (
        .push_i   (push_i),
        .pop_i    (pop_i),
        .drop_i   (drop_i),
        .ptr_we_i (ptr_we_i),
        .tos_we_i (tos_we_i),
        .op_o     (op)
    );

    rstk_ctrl #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_ctrl (
        .clk          (clk),
        .por_n        (por_n),
        .sys_rst_i    (sys_rst_i),
        .ovf_rst_en_i (ovf_rst_en_i),
        .op_i         (op),
        .push_addr_i  (push_addr_i),
        .ptr_wdata_i  (ptr_wdata_i),
        .tos_wdata_i  (tos_wdata_i),
        .flag_we_i    (flag_we_i),
        .flag_wdata_i (flag_wdata_i),
        .rd_data_i    (rd_data),
        .wr_en_o      (wr_en),
        .wr_idx_o     (wr_idx),
        .wr_data_o    (wr_data),
        .ptr_o        (ptr),
        .full_o       (full_o),
        .unf_o        (underflow_o),
        .req_o        (rst_req_o),
        .pop_vld_o    (pop_vld_o),
        .pop_addr_o   (pop_addr_o)
    );

    rstk_store #(.DEPTH(DEPTH), .AW(AW), .PW(PW)) u_store (
        .clk       (clk),
        .por_n     (por_n),
        .wr_en_i   (wr_en),
        .wr_idx_i  (wr_idx),
        .wr_data_i (wr_data),
        .rd_idx_i  (ptr),
        .rd_data_o (rd_data)
    );

    assign ptr_o = ptr;
    assign tos_o = rd_data;

endmodule

// File: tb/tb_call_return_stack.sv
module tb_call_return_stack;

    logic        clk = 1'b0;
    logic        por_n = 1'b0;
    logic        sys_rst_i = 1'b0, ovf_rst_en_i = 1'b0;
    logic        push_i = 1'b0, pop_i = 1'b0, drop_i = 1'b0;
    logic        ptr_we_i = 1'b0, tos_we_i = 1'b0, flag_we_i = 1'b0;
    logic [20:0] push_addr_i = '0, tos_wdata_i = '0;
    logic [4:0]  ptr_wdata_i = '0;
    logic [1:0]  flag_wdata_i = '0;
    logic        pop_vld_o, full_o, underflow_o, rst_req_o;
    logic [20:0] pop_addr_o, tos_o;
    logic [4:0]  ptr_o;

    int checks = 0, failures = 0;
    logic [20:0] exp_q [$];
    logic [20:0] mdl [0:31];
    int mptr = 0;

    always #10 clk = ~clk;

    call_return_stack dut (
        .clk(clk), .por_n(por_n), .sys_rst_i(sys_rst_i), .ovf_rst_en_i(ovf_rst_en_i),
        .push_i(push_i), .push_addr_i(push_addr_i), .pop_i(pop_i), .drop_i(drop_i),
        .ptr_we_i(ptr_we_i), .ptr_wdata_i(ptr_wdata_i), .tos_we_i(tos_we_i),
        .tos_wdata_i(tos_wdata_i), .flag_we_i(flag_we_i), .flag_wdata_i(flag_wdata_i),
        .pop_vld_o(pop_vld_o), .pop_addr_o(pop_addr_o), .ptr_o(ptr_o), .tos_o(tos_o),
        .full_o(full_o), .underflow_o(underflow_o), .rst_req_o(rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    // Monitor: every valid pop result is compared with the scoreboard head (R3)
    always @(negedge clk) begin
        if (por_n && pop_vld_o) begin
            if (exp_q.size() == 0) begin
                chk("R3/R10 unexpected pop_vld", 32'(pop_addr_o), 32'hFFFF_FFFF);
            end else begin
                logic [20:0] e;
                e = exp_q.pop_front();
                chk("R3/R6 pop data", 32'(pop_addr_o), 32'(e));
            end
        end
    end

    task automatic do_push(input logic [20:0] v);
        if (mptr < 31) begin mptr++; mdl[mptr] = v; end
        push_i = 1'b1; push_addr_i = v;
        cyc();
        push_i = 1'b0;
    endtask

    task automatic do_pop();
        exp_q.push_back(mptr == 0 ? 21'd0 : mdl[mptr]);
        if (mptr > 0) mptr--;
        pop_i = 1'b1;
        cyc();
        pop_i = 1'b0;
    endtask

    task automatic do_ptrwr(input int p);
        mptr = p;
        ptr_we_i = 1'b1; ptr_wdata_i = p[4:0];
        cyc();
        ptr_we_i = 1'b0;
    endtask

    task automatic do_flagwr(input logic [1:0] f);
        flag_we_i = 1'b1; flag_wdata_i = f;
        cyc();
        flag_we_i = 1'b0;
    endtask

    initial begin
        #(20 * 100000);
        failures++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        for (int i = 0; i < 32; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
        cyc();

        // R1: reset state
        chk("R1 ptr", 32'(ptr_o), 0);
        chk("R1 full", 32'(full_o), 0);
        chk("R1 underflow", 32'(underflow_o), 0);
        chk("R1 rst_req", 32'(rst_req_o), 0);
        chk("R1 tos", 32'(tos_o), 0);

        // R2: push three words
        do_push(21'h1A001); chk("R2 ptr after push", 32'(ptr_o), 1); chk("R2 tos", 32'(tos_o), 32'h1A001);
        do_push(21'h1A002);
        do_push(21'h1A003); chk("R2 ptr after 3 pushes", 32'(ptr_o), 3); chk("R2 tos", 32'(tos_o), 32'h1A003);

        // R3: pop back in reverse order
        do_pop(); do_pop(); do_pop();
        cyc();
        chk("R3 ptr back at 0", 32'(ptr_o), 0);
        chk("R3 scoreboard drained", exp_q.size(), 0);

        // R6: pop at 0, option off
        do_pop();
        chk("R6 underflow set", 32'(underflow_o), 1);
        chk("R6 ptr stays 0", 32'(ptr_o), 0);
        chk("R6 no reset request", 32'(rst_req_o), 0);

        // R7: software clear
        do_flagwr(2'b00);
        chk("R7 underflow cleared by write", 32'(underflow_o), 0);

        // R4: fill to the limit, option off
        for (int i = 1; i <= 31; i++) begin
            do_push(21'h0B000 + 21'(i));
            if (i == 30) chk("R4 full clear at 30", 32'(full_o), 0);
        end
        chk("R4 full at 31", 32'(full_o), 1);
        chk("R4 ptr 31", 32'(ptr_o), 31);
        do_push(21'h1FFFF);
        chk("R4 ptr held", 32'(ptr_o), 31);
        chk("R4 entry 31 kept", 32'(tos_o), 32'h0B01F);
        chk("R4 no reset request", 32'(rst_req_o), 0);

        // R7: system reset keeps flags, clears pointer
        sys_rst_i = 1'b1; cyc(); sys_rst_i = 1'b0; mptr = 0;
        chk("R7 ptr cleared by sys_rst", 32'(ptr_o), 0);
        chk("R7 full survives sys_rst", 32'(full_o), 1);

        // R8: pointer write, clamped value, then pop
        do_ptrwr(31);
        chk("R8 ptr written", 32'(ptr_o), 31);
        do_pop(); cyc();
        chk("R8 ptr after pop", 32'(ptr_o), 30);

        // R9: top-of-stack write
        tos_we_i = 1'b1; tos_wdata_i = 21'h12345; mdl[30] = 21'h12345; cyc(); tos_we_i = 1'b0;
        chk("R9 tos written", 32'(tos_o), 32'h12345);
        chk("R9 ptr unmoved", 32'(ptr_o), 30);
        do_ptrwr(0);
        tos_we_i = 1'b1; tos_wdata_i = 21'h0DEAD; cyc(); tos_we_i = 1'b0;
        chk("R9 tos at 0 reads 0", 32'(tos_o), 0);
        do_ptrwr(1);
        chk("R9 entry 1 untouched", 32'(tos_o), 32'h0B001);

        // R10: discard pop
        do_ptrwr(30);
        drop_i = 1'b1; cyc(); drop_i = 1'b0; mptr = 29;
        cyc();
        chk("R10 drop lowers ptr", 32'(ptr_o), 29);
        chk("R10 tos after drop", 32'(tos_o), 32'h0B01D);
        do_flagwr(2'b00);
        do_ptrwr(0);
        drop_i = 1'b1; cyc(); drop_i = 1'b0;
        chk("R10 drop at 0 sets underflow", 32'(underflow_o), 1);
        chk("R10 drop at 0 ptr", 32'(ptr_o), 0);

        // R5: overflow with reset option
        do_flagwr(2'b00);
        ovf_rst_en_i = 1'b1;
        do_ptrwr(30);
        do_push(21'h0C0DE);
        chk("R5 reset request", 32'(rst_req_o), 1);
        chk("R5 full set", 32'(full_o), 1);
        chk("R5 word stored", 32'(tos_o), 32'h0C0DE);
        cyc();
        chk("R5 request is a pulse", 32'(rst_req_o), 0);
        sys_rst_i = 1'b1; cyc(); sys_rst_i = 1'b0; mptr = 0;
        chk("R5 ptr 0 after reset", 32'(ptr_o), 0);
        chk("R5 full kept", 32'(full_o), 1);

        // R6: underflow with reset option, R7: event beats flag write
        do_flagwr(2'b00);
        exp_q.push_back(21'd0);
        pop_i = 1'b1; flag_we_i = 1'b1; flag_wdata_i = 2'b00;
        cyc();
        pop_i = 1'b0; flag_we_i = 1'b0;
        chk("R6 reset request on underflow", 32'(rst_req_o), 1);
        chk("R7 event wins over write", 32'(underflow_o), 1);
        ovf_rst_en_i = 1'b0;

        // R11: push beats pop and top write in the same cycle
        push_i = 1'b1; push_addr_i = 21'h0F00D; pop_i = 1'b1; tos_we_i = 1'b1; tos_wdata_i = 21'h00BAD;
        cyc();
        push_i = 1'b0; pop_i = 1'b0; tos_we_i = 1'b0;
        chk("R11 push took effect", 32'(ptr_o), 1);
        chk("R11 push word, not top write", 32'(tos_o), 32'h0F00D);
        ptr_we_i = 1'b1; ptr_wdata_i = 5'd7; push_i = 1'b1;
        cyc();
        ptr_we_i = 1'b0; push_i = 1'b0;
        chk("R11 pointer write beats push", 32'(ptr_o), 7);

        cyc();
        chk("R3 no stray pop results", exp_q.size(), 0);
        summary();
    end

endmodule